// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block takes one interrupt delivery request per cycle and turns it into injection strobes for a set of processor targets. A request carries a destination byte, a destination addressing mode, a delivery mode, a vector, a trigger flag and the number of the source pin. Alongside each request the block sees a target table. For every target slot the table holds a present flag, a physical identifier and a logical group mask.

The resolver first builds a selection mask over the targets. In physical addressing it picks the lowest-indexed present target whose identifier equals the destination, or every present target when the destination is the all-ones broadcast value. In logical addressing a zero destination selects nothing. Any other destination selects every present target whose group mask shares a bit with it. The dispatcher then applies the delivery mode. Fixed mode strobes every selected target and NMI mode raises the NMI strobe on them. Lowest-priority mode strobes a single target, which a rotating round-robin pointer chooses. Requests from source pin 0 are always steered to target 0.

Results are registered and appear as one-cycle pulses in the cycle after the request. A completion pulse reports whether any target was strobed.

Top module: `intr_dest_dispatch`

## Requirements
- R1: After reset every strobe, `done_valid` and `done_injected` are 0, and the round-robin pointer starts at target 0.
- R2: A request sampled with `req_valid` high at a rising edge produces `done_valid` high for exactly that next cycle. Strobes are only ever high in a cycle where `done_valid` is high.
- R3: In physical addressing (`req_dest_mode`=0) with a destination other than 0xFF, only the lowest-indexed present target whose physical ID equals the destination is selected. Absent targets never match.
- R4: In physical addressing with destination 0xFF, every present target is selected.
- R5: In logical addressing (`req_dest_mode`=1), destination 0 selects no target. Otherwise every present target whose logical mask ANDed with the destination is non-zero is selected.
- R6: When the selection mask is empty, no strobe is raised and `done_injected` is 0.
- R7: Delivery code 000 (fixed) raises `inj_strobe` on every selected target in the same cycle. The registered vector and trigger appear on `out_vector` and `out_trig` in that cycle.
- R8: Delivery code 100 (NMI) raises `nmi_strobe` on every selected target, and `inj_strobe` stays 0.
- R9: Delivery code 001 (lowest priority) strobes exactly one selected target. It is the first selected index at or after the pointer, wrapping past the top index. The pointer then moves to that index plus one, modulo the target count.
- R10: For source pin 0 the selection mask must still be non-empty. Then fixed mode strobes only target 0 if it is present, and lowest-priority mode strobes only target 0 if it is present. The pointer is left unchanged in that case.
- R11: Any delivery code other than 000, 001 and 100 raises no strobe and reports `done_injected` 0.
- R12: `done_injected` is 1 exactly when the completion pulse carries at least one injection or NMI strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Delivery request present this cycle |
| req_dest | input | DEST_W | Destination byte |
| req_dest_mode | input | 1 | 0 physical, 1 logical addressing |
| req_dlv_mode | input | 3 | Delivery code: 000 fixed, 001 lowest priority, 100 NMI |
| req_vector | input | VEC_W | Interrupt vector |
| req_trig | input | 1 | Trigger flag (1 level, 0 edge), passed through |
| req_pin | input | PIN_W | Source pin number |
| tgt_present | input | NUM_TGT | Per-target present flag |
| tgt_phys_id | input | NUM_TGT*DEST_W | Physical IDs, target i at bits [i*DEST_W +: DEST_W] |
| tgt_lmask | input | NUM_TGT*DEST_W | Logical masks, target i at bits [i*DEST_W +: DEST_W] |
| inj_strobe | output | NUM_TGT | Vector injection strobe per target |
| nmi_strobe | output | NUM_TGT | NMI strobe per target |
| out_vector | output | VEC_W | Vector of the completed request |
| out_trig | output | 1 | Trigger flag of the completed request |
| done_valid | output | 1 | Completion pulse |
| done_injected | output | 1 | Completion delivered to at least one target |

## Verification
The hardest states to reach are the wrap of the round-robin pointer past an absent target, and a pin-0 lowest-priority request that arrives while the pointer sits away from zero. The stimulus walks the pointer with a run of broadcast lowest-priority requests while target 6 is absent, so the pick must jump from 5 to 7 and then wrap to 0. Partway through, a pin-0 request is inserted, and the next ordinary request must resume from the pointer the bench model holds. A table with two targets that share a physical ID, and a pin-0 fixed request whose logical destination selects only target 2, cover the first-match and forced-routing corners.

// File: rtl/idd_pkg.sv
package idd_pkg;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_FIXED  = 2'd1,
      ACT_LOWEST = 2'd2,
      ACT_NMI    = 2'd3
   } idd_act_e;

   localparam logic [2:0] CODE_FIXED  = 3'b000;
   localparam logic [2:0] CODE_LOWEST = 3'b001;
   localparam logic [2:0] CODE_NMI    = 3'b100;

   function automatic idd_act_e decode_dlv(input logic [2:0] code);
      idd_act_e act;
      case (code)
         CODE_FIXED:  act = ACT_FIXED;
         CODE_LOWEST: act = ACT_LOWEST;
         CODE_NMI:    act = ACT_NMI;
         default:     act = ACT_NONE;
      endcase
      return act;
   endfunction

endpackage

// File: rtl/idd_match.sv
module idd_match #(
   parameter int NUM_TGT = 8,
   parameter int DEST_W  = 8
) (
   input  logic [DEST_W-1:0]         dest,
   input  logic                      dest_logical,
   input  logic [NUM_TGT-1:0]        present,
   input  logic [NUM_TGT*DEST_W-1:0] phys_id,
   input  logic [NUM_TGT*DEST_W-1:0] lmask,
   output logic [NUM_TGT-1:0]        sel_mask
);
   localparam logic [DEST_W-1:0] BCAST = '1;

   logic [NUM_TGT-1:0] phys_hit;
   logic [NUM_TGT-1:0] log_hit;
   logic [NUM_TGT-1:0] first_hit;
   logic [NUM_TGT:0]   seen;
   logic               is_bcast;
   logic               log_zero;

   assign is_bcast = (dest == BCAST);
   assign log_zero = (dest == '0);
   assign seen[0]  = 1'b0;

   for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
      logic [DEST_W-1:0] id_i;
      logic [DEST_W-1:0] lm_i;
      assign id_i         = phys_id[i*DEST_W +: DEST_W];
      assign lm_i         = lmask[i*DEST_W +: DEST_W];
      assign phys_hit[i]  = present[i] && (id_i == dest);
      assign log_hit[i]   = present[i] && (|(lm_i & dest));
      assign first_hit[i] = phys_hit[i] && !seen[i];
      assign seen[i+1]    = seen[i] | phys_hit[i];
   end

   always_comb begin
      if (dest_logical) begin
         sel_mask = log_zero ? '0 : log_hit;
      end else begin
         sel_mask = is_bcast ? present : first_hit;
      end
   end

endmodule

// File: rtl/idd_rr_pick.sv
module idd_rr_pick #(
   parameter int NUM_TGT  = 8,
   parameter int RR_STYLE = 0,
   parameter int IDX_W    = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
   input  logic [NUM_TGT-1:0] cand,
   input  logic [IDX_W-1:0]   ptr,
   output logic [IDX_W-1:0]   pick_idx,
   output logic               pick_any
);

   assign pick_any = |cand;

   if (RR_STYLE == 0) begin : g_rotate
      always_comb begin
         int  pos;
         logic found;
         found    = 1'b0;
         pick_idx = '0;
         for (int k = 0; k < NUM_TGT; k++) begin
            pos = (int'(ptr) + k) % NUM_TGT;
            if (!found && cand[pos]) begin
               found    = 1'b1;
               pick_idx = IDX_W'(pos);
            end
         end
      end
   end else begin : g_split
      logic [NUM_TGT-1:0] at_or_above;
      logic [NUM_TGT-1:0] upper;
      logic [NUM_TGT-1:0] pool;

      for (genvar i = 0; i < NUM_TGT; i++) begin : g_ge
         assign at_or_above[i] = (IDX_W'(i) >= ptr);
      end

      assign upper = cand & at_or_above;
      assign pool  = (|upper) ? upper : cand;

      always_comb begin
         pick_idx = '0;
         for (int k = NUM_TGT - 1; k >= 0; k--) begin
            if (pool[k]) pick_idx = IDX_W'(k);
         end
      end
   end

endmodule

// File: rtl/idd_dispatch.sv
module idd_dispatch
   import idd_pkg::*;
#(
   parameter int NUM_TGT = 8,
   parameter int IDX_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
   input  idd_act_e           act,
   input  logic [NUM_TGT-1:0] sel_mask,
   input  logic               pin_zero,
   input  logic               tgt0_present,
   input  logic [IDX_W-1:0]   pick_idx,
   input  logic               pick_any,
   output logic [NUM_TGT-1:0] inj_mask,
   output logic [NUM_TGT-1:0] nmi_mask,
   output logic               lp_advance
);
   logic [NUM_TGT-1:0] pick_oh;
   logic [NUM_TGT-1:0] only_t0;

   for (genvar i = 0; i < NUM_TGT; i++) begin : g_oh
      assign pick_oh[i] = (pick_idx == IDX_W'(i));
   end

   assign only_t0 = NUM_TGT'(tgt0_present);

   always_comb begin
      inj_mask   = '0;
      nmi_mask   = '0;
      lp_advance = 1'b0;
      if (|sel_mask) begin
         case (act)
            ACT_FIXED: begin
               inj_mask = pin_zero ? only_t0 : sel_mask;
            end
            ACT_LOWEST: begin
               if (pin_zero) begin
                  inj_mask = only_t0;
               end else begin
                  inj_mask   = pick_oh & {NUM_TGT{pick_any}};
                  lp_advance = pick_any;
               end
            end
            ACT_NMI: begin
               nmi_mask = sel_mask;
            end
            default: begin
               inj_mask = '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/intr_dest_dispatch.sv
module intr_dest_dispatch
   import idd_pkg::*;
#(
   parameter int NUM_TGT  = 8,
   parameter int DEST_W   = 8,
   parameter int VEC_W    = 8,
   parameter int PIN_W    = 5,
   parameter int RR_STYLE = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [DEST_W-1:0]         req_dest,
   input  logic                      req_dest_mode,
   input  logic [2:0]                req_dlv_mode,
   input  logic [VEC_W-1:0]          req_vector,
   input  logic                      req_trig,
   input  logic [PIN_W-1:0]          req_pin,
   input  logic [NUM_TGT-1:0]        tgt_present,
   input  logic [NUM_TGT*DEST_W-1:0] tgt_phys_id,
   input  logic [NUM_TGT*DEST_W-1:0] tgt_lmask,
   output logic [NUM_TGT-1:0]        inj_strobe,
   output logic [NUM_TGT-1:0]        nmi_strobe,
   output logic [VEC_W-1:0]          out_vector,
   output logic                      out_trig,
   output logic                      done_valid,
   output logic                      done_injected
);
   localparam int IDX_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TGT - 1);

   initial begin
      if (NUM_TGT < 1 || NUM_TGT > 64) $error("NUM_TGT must be 1..64");
      if (DEST_W < 2) $error("DEST_W must be at least 2");
      if (VEC_W < 1 || PIN_W < 1) $error("VEC_W and PIN_W must be positive");
      if (RR_STYLE != 0 && RR_STYLE != 1) $error("RR_STYLE must be 0 or 1");
   end

   idd_act_e           act;
   logic [NUM_TGT-1:0] sel_mask;
   logic [IDX_W-1:0]   ptr_q;
   logic [IDX_W-1:0]   pick_idx;
   logic               pick_any;
   logic [NUM_TGT-1:0] inj_mask;
   logic [NUM_TGT-1:0] nmi_mask;
   logic               lp_advance;
   logic               pin_zero;

   assign act      = decode_dlv(req_dlv_mode);
   assign pin_zero = (req_pin == '0);

   idd_match #(
      .NUM_TGT (NUM_TGT),
      .DEST_W  (DEST_W)
   ) u_match (
      .dest         (req_dest),
      .dest_logical (req_dest_mode),
      .present      (tgt_present),
      .phys_id      (tgt_phys_id),
      .lmask        (tgt_lmask),
      .sel_mask     (sel_mask)
   );

   idd_rr_pick #(
      .NUM_TGT  (NUM_TGT),
      .RR_STYLE (RR_STYLE),
      .IDX_W    (IDX_W)
   ) u_pick (
      .cand     (sel_mask),
      .ptr      (ptr_q),
      .pick_idx (pick_idx),
      .pick_any (pick_any)
   );

   idd_dispatch #(
      .NUM_TGT (NUM_TGT),
      .IDX_W   (IDX_W)
   ) u_disp (
      .act          (act),
      .sel_mask     (sel_mask),
      .pin_zero     (pin_zero),
      .tgt0_present (tgt_present[0]),
      .pick_idx     (pick_idx),
      .pick_any     (pick_any),
      .inj_mask     (inj_mask),
      .nmi_mask     (nmi_mask),
      .lp_advance   (lp_advance)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inj_strobe    <= '0;
         nmi_strobe    <= '0;
         out_vector    <= '0;
         out_trig      <= 1'b0;
         done_valid    <= 1'b0;
         done_injected <= 1'b0;
         ptr_q         <= '0;
      end else begin
         done_valid <= req_valid;
         if (req_valid) begin
            inj_strobe    <= inj_mask;
            nmi_strobe    <= nmi_mask;
            out_vector    <= req_vector;
            out_trig      <= req_trig;
            done_injected <= (|inj_mask) | (|nmi_mask);
            if (lp_advance) begin
               ptr_q <= (pick_idx == LAST_IDX) ? '0 : pick_idx + IDX_W'(1);
            end
         end else begin
            inj_strobe    <= '0;
            nmi_strobe    <= '0;
            done_injected <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/idd_checker.sv
module idd_checker #(
   parameter int NUM_TGT = 8,
   parameter int DEST_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [DEST_W-1:0]  req_dest,
   input logic               req_dest_mode,
   input logic [2:0]         req_dlv_mode,
   input logic               pin_zero,
   input logic [NUM_TGT-1:0] tgt_present,
   input logic [NUM_TGT-1:0] inj_strobe,
   input logic [NUM_TGT-1:0] nmi_strobe,
   input logic               done_valid,
   input logic               done_injected
);
   logic supported;
   assign supported = (req_dlv_mode == 3'b000) || (req_dlv_mode == 3'b001) ||
                      (req_dlv_mode == 3'b100);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (inj_strobe == '0 && nmi_strobe == '0 && !done_valid && !done_injected));

   assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> done_valid);

   assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !done_valid);

   assert_strobe_in_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((|inj_strobe) || (|nmi_strobe)) |-> done_valid);

   assert_phys_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_dest_mode && req_dest != '1) |=> ($countones(inj_strobe | nmi_strobe) <= 1));

   assert_bcast_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_dest_mode && req_dest == '1 && req_dlv_mode == 3'b000 && !pin_zero)
      |=> (inj_strobe == $past(tgt_present)));

   assert_logical_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_dest_mode && req_dest == '0) |=> !done_injected);

   assert_nmi_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|nmi_strobe) |-> (inj_strobe == '0));

   assert_lowest_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_dlv_mode == 3'b001) |=> $onehot0(inj_strobe));

   assert_unsupported_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !supported) |=> (!done_injected && inj_strobe == '0 && nmi_strobe == '0));

   assert_injected_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (done_injected == ((|inj_strobe) || (|nmi_strobe))));

endmodule

bind intr_dest_dispatch idd_checker #(
   .NUM_TGT (NUM_TGT),
   .DEST_W  (DEST_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_dest      (req_dest),
   .req_dest_mode (req_dest_mode),
   .req_dlv_mode  (req_dlv_mode),
   .pin_zero      (pin_zero),
   .tgt_present   (tgt_present),
   .inj_strobe    (inj_strobe),
   .nmi_strobe    (nmi_strobe),
   .done_valid    (done_valid),
   .done_injected (done_injected)
);

// File: tb/intr_dest_dispatch_tb.sv
`timescale 1ns/1ps
module intr_dest_dispatch_tb;
   localparam int N  = 8;
   localparam int DW = 8;
   localparam int VW = 8;
   localparam int PW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [DW-1:0] req_dest = '0;
   logic          req_dest_mode = 1'b0;
   logic [2:0]    req_dlv_mode = 3'b000;
   logic [VW-1:0] req_vector = '0;
   logic          req_trig = 1'b0;
   logic [PW-1:0] req_pin = '0;
   logic [N-1:0]  tgt_present;
   logic [N*DW-1:0] tgt_phys_id;
   logic [N*DW-1:0] tgt_lmask;
   logic [N-1:0]  inj_strobe;
   logic [N-1:0]  nmi_strobe;
   logic [VW-1:0] out_vector;
   logic          out_trig;
   logic          done_valid;
   logic          done_injected;

   int checks = 0;
   int errors = 0;
   int model_ptr = 0;
   logic [N-1:0] s_inj, s_nmi;
   logic s_done, s_injd;

   always #5 clk = ~clk;

   intr_dest_dispatch #(.NUM_TGT(N), .DEST_W(DW), .VEC_W(VW), .PIN_W(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
      .req_dest_mode(req_dest_mode), .req_dlv_mode(req_dlv_mode),
      .req_vector(req_vector), .req_trig(req_trig), .req_pin(req_pin),
      .tgt_present(tgt_present), .tgt_phys_id(tgt_phys_id), .tgt_lmask(tgt_lmask),
      .inj_strobe(inj_strobe), .nmi_strobe(nmi_strobe), .out_vector(out_vector),
      .out_trig(out_trig), .done_valid(done_valid), .done_injected(done_injected));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] dest, input logic dmode, input logic [2:0] dlv,
                       input logic [7:0] vec, input logic trig, input logic [4:0] pin);
      @(negedge clk);
      req_valid = 1'b1; req_dest = dest; req_dest_mode = dmode; req_dlv_mode = dlv;
      req_vector = vec; req_trig = trig; req_pin = pin;
      @(negedge clk);
      req_valid = 1'b0;
      s_inj = inj_strobe; s_nmi = nmi_strobe; s_done = done_valid; s_injd = done_injected;
   endtask

   function automatic int rr_pick(input logic [N-1:0] m, input int p);
      for (int k = 0; k < N; k++) begin
         if (m[(p + k) % N]) return (p + k) % N;
      end
      return -1;
   endfunction

   task automatic t_reset;
      chk("R1 inj_strobe after reset", 64'(inj_strobe), 0);
      chk("R1 nmi_strobe after reset", 64'(nmi_strobe), 0);
      chk("R1 done_valid after reset", 64'(done_valid), 0);
      chk("R1 done_injected after reset", 64'(done_injected), 0);
   endtask

   task automatic t_pulse;
      send(8'h11, 1'b0, 3'b000, 8'h30, 1'b0, 5'd3);
      chk("R2 done_valid pulse", 64'(s_done), 1);
      @(negedge clk);
      chk("R2 done_valid drops", 64'(done_valid), 0);
      chk("R2 strobes drop", 64'({inj_strobe, nmi_strobe}), 0);
   endtask

   task automatic t_physical;
      send(8'h12, 1'b0, 3'b000, 8'h41, 1'b1, 5'd4);
      chk("R3 phys match id 0x12", 64'(s_inj), 64'h04);
      chk("R7 out_vector", 64'(out_vector), 64'h41);
      chk("R7 out_trig", 64'(out_trig), 1);
      chk("R12 injected flag", 64'(s_injd), 1);
      send(8'h42, 1'b0, 3'b000, 8'h42, 1'b0, 5'd4);
      chk("R3 first of duplicate id", 64'(s_inj), 64'h08);
      send(8'h16, 1'b0, 3'b000, 8'h43, 1'b0, 5'd4);
      chk("R6 absent target no strobe", 64'(s_inj), 0);
      chk("R6 absent target not injected", 64'(s_injd), 0);
   endtask

   task automatic t_broadcast;
      send(8'hFF, 1'b0, 3'b000, 8'h50, 1'b0, 5'd2);
      chk("R4 broadcast fixed", 64'(s_inj), 64'(tgt_present));
      chk("R7 broadcast fixed no nmi", 64'(s_nmi), 0);
   endtask

   task automatic t_logical;
      send(8'h00, 1'b1, 3'b000, 8'h60, 1'b0, 5'd2);
      chk("R5 logical zero dest", 64'(s_inj), 0);
      chk("R6 logical zero not injected", 64'(s_injd), 0);
      send(8'h26, 1'b1, 3'b000, 8'h61, 1'b0, 5'd2);
      chk("R5 logical 0x26", 64'(s_inj), 64'h26);
      send(8'h01, 1'b1, 3'b000, 8'h62, 1'b0, 5'd2);
      chk("R5 logical overlap 0x01", 64'(s_inj), 64'h81);
      send(8'h40, 1'b1, 3'b000, 8'h63, 1'b0, 5'd2);
      chk("R5 logical absent only", 64'(s_inj), 0);
   endtask

   task automatic t_nmi;
      send(8'h26, 1'b1, 3'b100, 8'h70, 1'b0, 5'd1);
      chk("R8 nmi strobes", 64'(s_nmi), 64'h26);
      chk("R8 nmi no inj", 64'(s_inj), 0);
      chk("R12 nmi injected", 64'(s_injd), 1);
   endtask

   task automatic t_unsupported;
      send(8'hFF, 1'b0, 3'b010, 8'h71, 1'b0, 5'd1);
      chk("R11 code 010 no strobe", 64'({s_inj, s_nmi}), 0);
      chk("R11 code 010 not injected", 64'(s_injd), 0);
      send(8'hFF, 1'b0, 3'b111, 8'h72, 1'b0, 5'd1);
      chk("R11 code 111 no strobe", 64'({s_inj, s_nmi}), 0);
   endtask

   task automatic t_lowest;
      for (int r = 0; r < 9; r++) begin
         int exp_i;
         exp_i = rr_pick(tgt_present, model_ptr);
         send(8'hFF, 1'b0, 3'b001, 8'h80, 1'b0, 5'd7);
         chk("R9 round robin broadcast", 64'(s_inj), 64'(1) << exp_i);
         model_ptr = (exp_i + 1) % N;
      end
      begin
         int exp_i;
         exp_i = rr_pick(8'h24, model_ptr);
         send(8'h24, 1'b1, 3'b001, 8'h81, 1'b0, 5'd7);
         chk("R9 round robin logical", 64'(s_inj), 64'(1) << exp_i);
         model_ptr = (exp_i + 1) % N;
      end
   endtask

   task automatic t_pin0;
      send(8'hFF, 1'b0, 3'b000, 8'h90, 1'b0, 5'd0);
      chk("R10 pin0 fixed broadcast", 64'(s_inj), 64'h01);
      send(8'h04, 1'b1, 3'b000, 8'h91, 1'b0, 5'd0);
      chk("R10 pin0 fixed forced to t0", 64'(s_inj), 64'h01);
      send(8'h24, 1'b1, 3'b001, 8'h92, 1'b0, 5'd0);
      chk("R10 pin0 lowest to t0", 64'(s_inj), 64'h01);
      begin
         int exp_i;
         exp_i = rr_pick(tgt_present, model_ptr);
         send(8'hFF, 1'b0, 3'b001, 8'h93, 1'b0, 5'd9);
         chk("R10 pointer kept after pin0", 64'(s_inj), 64'(1) << exp_i);
         model_ptr = (exp_i + 1) % N;
      end
      tgt_present[0] = 1'b0;
      send(8'hFF, 1'b0, 3'b000, 8'h94, 1'b0, 5'd0);
      chk("R10 pin0 t0 absent no strobe", 64'(s_inj), 0);
      chk("R12 pin0 t0 absent not injected", 64'(s_injd), 0);
      tgt_present[0] = 1'b1;
   endtask

   initial begin
      tgt_present = 8'b1011_1111;
      for (int i = 0; i < N; i++) begin
         tgt_phys_id[i*DW +: DW] = 8'h10 + 8'(i);
         tgt_lmask[i*DW +: DW]   = 8'(1) << i;
      end
      tgt_phys_id[3*DW +: DW] = 8'h42;
      tgt_phys_id[5*DW +: DW] = 8'h42;
      tgt_lmask[7*DW +: DW]   = 8'h81;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_pulse;
      t_physical;
      t_broadcast;
      t_logical;
      t_nmi;
      t_unsupported;
      t_lowest;
      t_pin0;
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule